// File: doc/BRIEF.md
# Byte-Region Checksum Engine

This engine walks a byte-addressed memory region through a simple request/response port and folds its contents into a 16-bit checksum. The fold works on a nibble basis: each step mixes a 16-bit input word into the running value with shifts and XORs rather than a bitwise polynomial division. The words are big-endian pairs of neighbouring bytes, and each pair shares one byte with the pair before it. The engine therefore fetches each byte once and reuses the previous byte as the high half of the next word.

A caller drives a base address, a byte count and an optional write-back address, then pulses start. The engine streams one byte read per cycle, and memory returns data one cycle after each request. When the count is odd, the engine folds one extra word made of the trailing byte and a zero. In write-back mode it then stores the result as two byte writes, high byte first. A one-cycle done pulse marks the end of a job. The checksum stays on its output until the next job begins. A typical use covers a 248-byte parameter area starting at offset 0 and stores the result at offsets 0xFC/0xFD.

Top module: `nvsum_engine`

## Requirements
- R1: After reset, busy_o and done_o are 0, sum_o is 0xFFFF and mem_req_o is 0.
- R2: Each fold step computes, from running value p and word v: d = p^v, a = d[3:0], b = d[7:4]^a, next = (p>>8) ^ (a<<3) ^ (a<<8) ^ b ^ (b<<7) ^ (b<<12), kept to 16 bits. The running value starts at 0xFFFF.
- R3: For a count N, let E = N with bit 0 cleared. For every i from 0 to E-1, the engine folds the word {byte[base+i], byte[base+i+1]} (first byte in bits 15:8), in increasing i.
- R4: When N is odd, the engine applies one further fold with word {byte[base+E], 8'h00}.
- R5: A start with count 0 and write-back off raises done_o in the cycle after start, with sum_o = 0xFFFF and no memory request.
- R6: For N > 0 the engine issues exactly E+1 read requests, at consecutive addresses from base_i (wrapping at the address width). It samples mem_rdata_i in the cycle after each request. It never requests memory while idle.
- R7: A start pulse while busy_o is 1 is ignored. The running job's reads and result are unchanged.
- R8: done_o is high for exactly one cycle per job, with busy_o low. sum_o holds the result until the next accepted start.
- R9: With write-back on, after the last fold the engine writes sum[15:8] to wb_addr_i and then sum[7:0] to wb_addr_i+1, on consecutive cycles with mem_we_o = 1. done_o follows the second write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only while idle |
| base_i | input | AW | First byte address of the region |
| count_i | input | CW | Number of bytes in the region |
| wb_en_i | input | 1 | Store the result into memory when set |
| wb_addr_i | input | AW | Address of the result's high byte |
| mem_req_o | output | 1 | Memory request strobe |
| mem_we_o | output | 1 | Request is a write when 1, a read when 0 |
| mem_addr_o | output | AW | Request byte address |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data, valid the cycle after a read request |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | One-cycle completion pulse |
| sum_o | output | 16 | Checksum result |

## Verification
A stale cached byte, or a receive counter off by one, corrupts the running fold at the first affected step. Because every later fold mixes that error into all sixteen bits, the wrong value reaches sum_o at the done pulse of the same job. A wrong issue count or a lost odd-byte flag shows at the memory port as one read too many or too few, or as an address that jumps. It also shows as a checksum that differs from the model on odd counts only. Write-back ordering faults show as swapped bytes in memory, checked right after done.

// File: rtl/nvsum_pkg.sv
// Shared types and constants for the byte-region checksum engine.
package nvsum_pkg;

    // Sequencer states of the engine.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STREAM,
        ST_TAIL,
        ST_WHI,
        ST_WLO
    } nvs_state_e;

    // Value the running checksum holds before the first fold.
    localparam logic [15:0] SUM_SEED = 16'hFFFF;

endpackage

// File: rtl/nvsum_fold.sv
// nvsum_fold: one combinational step of the nibble-folded checksum.
// Assumes: a purely combinational use; the caller registers the result.
module nvsum_fold (
    input  logic [15:0] prev_i,
    input  logic [15:0] word_i,
    output logic [15:0] next_o
);
    logic [15:0] mix;
    logic [3:0]  lo_nib;
    logic [3:0]  hi_nib;

    // Fold the low byte of (prev ^ word) into the shifted previous value.
    always_comb begin
        mix    = prev_i ^ word_i;
        lo_nib = mix[3:0];
        hi_nib = mix[7:4] ^ lo_nib;
        next_o = {8'h00, prev_i[15:8]}
               ^ {9'b0, lo_nib, 3'b0}
               ^ {4'b0, lo_nib, 8'b0}
               ^ {12'b0, hi_nib}
               ^ {5'b0, hi_nib, 7'b0}
               ^ {hi_nib, 12'b0};
    end
endmodule

// File: rtl/nvsum_fetch.sv
// nvsum_fetch: streams byte reads at consecutive addresses, one per cycle.
// It tags each returned byte as first and/or last.
// Assumes: memory returns read data exactly one cycle after the request.
// load_i is only pulsed while no earlier stream is still in flight.
module nvsum_fetch #(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [AW-1:0] base_i,
    input  logic [CW:0]   total_i,
    input  logic [7:0]    rdata_i,
    output logic          req_o,
    output logic [AW-1:0] addr_o,
    output logic          byte_vld_o,
    output logic          byte_first_o,
    output logic          byte_last_o,
    output logic [7:0]    byte_o
);
    logic [CW:0]   issued_q;
    logic [CW:0]   rcvd_q;
    logic [CW:0]   total_q;
    logic          active_q;
    logic          pend_q;
    logic [AW-1:0] addr_q;

    assign req_o        = active_q && (issued_q != total_q);
    assign addr_o       = addr_q;
    assign byte_vld_o   = pend_q;
    assign byte_first_o = (rcvd_q == '0);
    assign byte_last_o  = (rcvd_q == total_q - (CW+1)'(1));
    assign byte_o       = rdata_i;

    // Issue and receive bookkeeping for the current stream.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            issued_q <= '0;
            rcvd_q   <= '0;
            total_q  <= '0;
            active_q <= 1'b0;
            pend_q   <= 1'b0;
            addr_q   <= '0;
        end else if (load_i) begin
            issued_q <= '0;
            rcvd_q   <= '0;
            total_q  <= total_i;
            active_q <= (total_i != '0);
            pend_q   <= 1'b0;
            addr_q   <= base_i;
        end else begin
            pend_q <= req_o;
            if (req_o) begin
                addr_q   <= addr_q + AW'(1);
                issued_q <= issued_q + (CW+1)'(1);
            end
            if (pend_q) begin
                rcvd_q <= rcvd_q + (CW+1)'(1);
                if (byte_last_o) begin
                    active_q <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/nvsum_engine.sv
// nvsum_engine: checksums a byte region over overlapping big-endian words.
// The odd trailing byte gets its own fold, and the result can be stored back.
// Assumes: single-port byte memory with one-cycle read latency; start_i is
// ignored while a job runs.
module nvsum_engine #(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [AW-1:0] base_i,
    input  logic [CW-1:0] count_i,
    input  logic          wb_en_i,
    input  logic [AW-1:0] wb_addr_i,
    output logic          mem_req_o,
    output logic          mem_we_o,
    output logic [AW-1:0] mem_addr_o,
    output logic [7:0]    mem_wdata_o,
    input  logic [7:0]    mem_rdata_i,
    output logic          busy_o,
    output logic          done_o,
    output logic [15:0]   sum_o
);
    import nvsum_pkg::*;

    nvs_state_e    state_q;
    logic [15:0]   sum_q;
    logic [7:0]    prev_q;
    logic          odd_q;
    logic          wb_q;
    logic [AW-1:0] wba_q;
    logic          done_q;

    logic          launch;
    logic [CW-1:0] even_cnt;
    logic [CW:0]   read_total;
    logic          f_req;
    logic [AW-1:0] f_addr;
    logic          f_vld;
    logic          f_first;
    logic          f_last;
    logic [7:0]    f_byte;
    logic [15:0]   fold_word;
    logic [15:0]   fold_next;

    assign launch     = start_i && (state_q == ST_IDLE);
    assign even_cnt   = {count_i[CW-1:1], 1'b0};
    assign read_total = (count_i == '0) ? '0 : ({1'b0, even_cnt} + (CW+1)'(1));

    nvsum_fetch #(.AW(AW), .CW(CW)) u_fetch (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (launch),
        .base_i       (base_i),
        .total_i      (read_total),
        .rdata_i      (mem_rdata_i),
        .req_o        (f_req),
        .addr_o       (f_addr),
        .byte_vld_o   (f_vld),
        .byte_first_o (f_first),
        .byte_last_o  (f_last),
        .byte_o       (f_byte)
    );

    // Pick the word to fold: cached byte with new byte, or with a zero tail.
    assign fold_word = (state_q == ST_TAIL) ? {prev_q, 8'h00} : {prev_q, f_byte};

    nvsum_fold u_fold (
        .prev_i (sum_q),
        .word_i (fold_word),
        .next_o (fold_next)
    );

    // Job sequencing, checksum accumulation and done generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sum_q   <= SUM_SEED;
            prev_q  <= '0;
            odd_q   <= 1'b0;
            wb_q    <= 1'b0;
            wba_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (launch) begin
                        sum_q <= SUM_SEED;
                        odd_q <= count_i[0];
                        wb_q  <= wb_en_i;
                        wba_q <= wb_addr_i;
                        if (count_i != '0) begin
                            state_q <= ST_STREAM;
                        end else if (wb_en_i) begin
                            state_q <= ST_WHI;
                        end else begin
                            done_q <= 1'b1;
                        end
                    end
                end
                ST_STREAM: begin
                    if (f_vld) begin
                        prev_q <= f_byte;
                        if (!f_first) begin
                            sum_q <= fold_next;
                        end
                        if (f_last) begin
                            state_q <= ST_TAIL;
                        end
                    end
                end
                ST_TAIL: begin
                    if (odd_q) begin
                        sum_q <= fold_next;
                    end
                    if (wb_q) begin
                        state_q <= ST_WHI;
                    end else begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end
                end
                ST_WHI: begin
                    state_q <= ST_WLO;
                end
                ST_WLO: begin
                    state_q <= ST_IDLE;
                    done_q  <= 1'b1;
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    // Memory port: reads from the fetcher, or the two result writes.
    always_comb begin
        mem_we_o    = (state_q == ST_WHI) || (state_q == ST_WLO);
        mem_req_o   = f_req || mem_we_o;
        mem_addr_o  = f_addr;
        mem_wdata_o = sum_q[7:0];
        if (state_q == ST_WHI) begin
            mem_addr_o  = wba_q;
            mem_wdata_o = sum_q[15:8];
        end else if (state_q == ST_WLO) begin
            mem_addr_o  = wba_q + AW'(1);
        end
    end

    assign busy_o = (state_q != ST_IDLE);
    assign done_o = done_q;
    assign sum_o  = sum_q;
endmodule

// File: rtl/nvsum_engine_chk.sv
// nvsum_engine_chk: port-level protocol checks for nvsum_engine.
// Assumes: attached by the bind below; observes ports only.
module nvsum_engine_chk #(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic [CW-1:0] count_i,
    input logic          wb_en_i,
    input logic          mem_req_o,
    input logic          mem_we_o,
    input logic [AW-1:0] mem_addr_o,
    input logic          busy_o,
    input logic          done_o,
    input logic [15:0]   sum_o
);
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    assert_req_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> busy_o);

    assert_read_seq_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_we_o && $past(mem_req_o && !mem_we_o))
        |-> (mem_addr_o == $past(mem_addr_o) + AW'(1)));

    assert_zero_quick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && count_i == '0 && !wb_en_i)
        |=> (done_o && sum_o == 16'hFFFF));

    assert_wb_pair_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_o) |=> (mem_we_o && mem_addr_o == $past(mem_addr_o) + AW'(1)));

    assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> (busy_o || done_o));
endmodule

bind nvsum_engine nvsum_engine_chk #(.AW(AW), .CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .count_i    (count_i),
    .wb_en_i    (wb_en_i),
    .mem_req_o  (mem_req_o),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .sum_o      (sum_o)
);

// File: tb/sim_nvsum_engine.sv
`timescale 1ns/1ps
// sim_nvsum_engine: random and directed jobs checked against a bench model.
module sim_nvsum_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] base = '0;
    logic [15:0] count = '0;
    logic        wb_en = 1'b0;
    logic [15:0] wb_addr = '0;
    logic        mem_req, mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata;
    logic        busy, done;
    logic [15:0] sum;

    int n_checks = 0;
    int n_fail = 0;
    int rd_cnt = 0;
    int wr_cnt = 0;
    logic [7:0] mem [0:65535];

    always #2 clk = ~clk;

    nvsum_engine #(.AW(16), .CW(16)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .base_i(base), .count_i(count),
        .wb_en_i(wb_en), .wb_addr_i(wb_addr), .mem_req_o(mem_req), .mem_we_o(mem_we),
        .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
        .busy_o(busy), .done_o(done), .sum_o(sum)
    );

    // Byte memory with one-cycle read latency, plus request counters.
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) begin
                mem[mem_addr] <= mem_wdata;
                wr_cnt = wr_cnt + 1;
            end else begin
                mem_rdata <= mem[mem_addr];
                rd_cnt = rd_cnt + 1;
            end
        end
    end

    function automatic logic [15:0] model_step(logic [15:0] p, logic [15:0] v);
        logic [15:0] d, a, b, r;
        d = p ^ v;
        a = d & 16'h000F;
        b = ((d >> 4) & 16'h000F) ^ a;
        r = (p >> 8) ^ (a << 3) ^ (a << 8) ^ b ^ (b << 7) ^ (b << 12);
        return r;
    endfunction

    function automatic logic [15:0] model_sum(logic [15:0] b0, logic [15:0] n);
        logic [15:0] acc = 16'hFFFF;
        logic [15:0] e = n & 16'hFFFE;
        for (int i = 0; i < int'(e); i++)
            acc = model_step(acc, {mem[16'(b0 + 16'(i))], mem[16'(b0 + 16'(i) + 16'd1)]});
        if (n[0]) acc = model_step(acc, {mem[16'(b0 + e)], 8'h00});
        return acc;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // One job; intrude pulses a second start mid-run (R7).
    task automatic run_job(input logic [15:0] b0, input logic [15:0] n, input bit wb,
                           input logic [15:0] wba, input bit intrude, input string req);
        logic [15:0] exp = model_sum(b0, n);
        int exp_rd = (n == 0) ? 0 : int'(n & 16'hFFFE) + 1;
        int cyc = 0;
        @(negedge clk);
        rd_cnt = 0; wr_cnt = 0;
        base = b0; count = n; wb_en = wb; wb_addr = wba; start = 1'b1;
        @(negedge clk); cyc = 1;
        start = 1'b0;
        while (!done && cyc < 4000) begin
            if (intrude && cyc == 5) begin
                start = 1'b1; base = b0 ^ 16'h1234; count = 16'd7; wb_en = 1'b0;
            end
            @(negedge clk); cyc++;
            start = 1'b0;
        end
        check(done == 1'b1, "R8", "done seen", int'(done), 1);
        if (n == 0 && !wb) check(cyc == 1, "R5", "zero-count latency", cyc, 1);
        check(sum == exp, req, "checksum", int'(sum), int'(exp));
        check(rd_cnt == exp_rd, "R6", "read count", rd_cnt, exp_rd);
        if (wb) begin
            check(wr_cnt == 2, "R9", "write count", wr_cnt, 2);
            check(mem[wba] == exp[15:8], "R9", "high byte", int'(mem[wba]), int'(exp[15:8]));
            check(mem[16'(wba + 16'd1)] == exp[7:0], "R9", "low byte",
                  int'(mem[16'(wba + 16'd1)]), int'(exp[7:0]));
        end
        @(negedge clk);
        check(done == 1'b0, "R8", "done width", int'(done), 0);
        @(negedge clk); @(negedge clk);
        check(sum == exp, "R8", "sum held", int'(sum), int'(exp));
    endtask

    // Global watchdog.
    initial begin
        #(4 * 190000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < 65536; i++) mem[i] = 8'($urandom);
        mem_rdata = '0;
        repeat (3) @(negedge clk);
        check(!busy && !done && sum == 16'hFFFF && !mem_req, "R1", "reset state",
              int'(sum), 16'hFFFF);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !mem_req, "R1", "idle after reset", int'(busy), 0);

        // R2: three known bytes, count 2 (two overlapping words).
        mem[16'h0400] = 8'h12; mem[16'h0401] = 8'h34; mem[16'h0402] = 8'h56;
        run_job(16'h0400, 16'd2, 1'b0, 16'h0, 1'b0, "R2");
        // R5: empty region.
        run_job(16'h1000, 16'd0, 1'b0, 16'h0, 1'b0, "R5");
        // R4: single byte, then small odd count.
        run_job(16'h2000, 16'd1, 1'b0, 16'h0, 1'b0, "R4");
        run_job(16'h2100, 16'd5, 1'b0, 16'h0, 1'b0, "R4");
        // R3: even count wrapping the address space.
        run_job(16'hFFF8, 16'd12, 1'b0, 16'h0, 1'b0, "R3");
        // R9: standard parameter area with result at 0xFC.
        run_job(16'h0000, 16'h00F8, 1'b1, 16'h00FC, 1'b0, "R9");
        // R7: start pulse while busy.
        run_job(16'h3000, 16'd100, 1'b0, 16'h0, 1'b1, "R7");
        // Random jobs, region and result kept apart.
        for (int k = 0; k < 40; k++) begin
            logic [15:0] rb = 16'($urandom_range(32'h0400, 32'h7000));
            logic [15:0] rn = 16'($urandom_range(0, 300));
            bit rw = 1'($urandom);
            run_job(rb, rn, rw, 16'hC000 + 16'(k * 4), 1'b0, rn[0] ? "R4" : "R3");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule